// File: doc/BRIEF.md
# Variable-Field-Width SIMD Execute Unit

This block is the execute stage of a SIMD datapath whose register is split into equal fields of any power-of-two width, from single bits up to the whole register. Each cycle it takes two register-wide operands with an opcode and a field-width code, both already decoded upstream. It computes the selected operation independently in every field. The result is registered once and handed to the write-back stage. The operations are wrapping add and subtract, logical shifts by a per-field count, narrowing pack, and high or low interleaving merge.

The field-width code `k` selects fields of `2^k` bits. Every operation exists at every width that makes sense. This includes 1-, 2- and 4-bit fields and, for merge, single-bit fields. An operation that has no meaning at the chosen width returns zero, and so does an unused width code or opcode.

Top module: `simd_exec`

## Requirements
- R1: `out_valid` and `result` are registered one clock after the input that produced them. `out_valid` equals the previous cycle's `in_valid`, and reset clears both to zero.
- R2: Opcode 0 adds the matching fields modulo 2^n, with no carry crossing a field boundary. At n = 1 this is a bitwise exclusive-or.
- R3: Opcode 1 subtracts each field of `op_b` from the matching field of `op_a`, modulo 2^n.
- R4: Opcode 2 shifts each `op_a` field left by the count held in the low log2(n) bits of the matching `op_b` field. The field's higher bits play no part, bits pushed out are lost, and at n = 1 the count is zero.
- R5: Opcode 3 is the matching logical right shift, filling vacated bits with zero.
- R6: Opcode 4 (pack) keeps the low n/2 bits of every field. The `op_a` results fill the upper half of the result and the `op_b` results fill the lower half, with field order kept in each half.
- R7: Opcode 5 (merge-high) and opcode 6 (merge-low) take the n-bit fields of the upper (or lower) halves of both operands and interleave them. Field i of `op_a`'s half goes to result field 2i+1, and field i of `op_b`'s half goes to result field 2i.
- R8: Merge is supported with 1-bit fields, interleaving single bits of the two operands.
- R9: The result is all zero for pack at k = 0, merge at k = K (whole-register fields), any width code above K, and opcode 7.
- R10: While `in_valid` is low, `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | N (64) | First operand |
| op_b | input | N (64) | Second operand, also the per-field shift counts |
| opcode | input | 3 | Decoded operation (0 add, 1 sub, 2 shl, 3 shr, 4 pack, 5 merge-high, 6 merge-low, 7 reserved) |
| fw_code | input | clog2(K+1) (3) | Field width is 2^fw_code bits |
| out_valid | output | 1 | Result valid for write-back |
| result | output | N (64) | Registered result |

## Verification
The bench puts carries at field edges: 0xFF+0x01 bytes and all-ones plus 0x55 pairs. A unit that let a carry cross into the next field would corrupt the field above. Shift counts with their upper bits set catch a design that uses the whole field as the count, and such a design would clear the field. Pack and both merges run at 1-bit, 16-bit and whole-half widths with distinct hex digits in every field. Any swap of operands or halves shows up as misplaced digits. The zero cases (pack at 1 bit, merge at full width, unused width code and opcode) and the hold of the result while idle catch a unit that would return stale or partial data.

// File: rtl/simd_exec_pkg.sv
package simd_exec_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_PACK = 3'd4,
        OP_MRGH = 3'd5,
        OP_MRGL = 3'd6,
        OP_RSVD = 3'd7
    } simd_op_e;

endpackage

// File: rtl/simd_lane_alu.sv
// Per-field arithmetic and shifts for one fixed field width FW.
module simd_lane_alu #(
    parameter int N  = 64,
    parameter int FW = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] sum,
    output logic [N-1:0] dif,
    output logic [N-1:0] shl,
    output logic [N-1:0] shr
);
    localparam int NF = N / FW;
    localparam int SW = (FW > 1) ? $clog2(FW) : 1;

    generate
        if (FW == 1) begin : g_bit
            // one-bit fields: add and subtract are both xor, count is zero
            assign sum = a ^ b;
            assign dif = a ^ b;
            assign shl = a;
            assign shr = a;
        end else begin : g_multi
            for (genvar f = 0; f < NF; f++) begin : g_fld
                logic [FW-1:0] fa;
                logic [FW-1:0] fb;
                logic [SW-1:0] cnt;
                assign fa  = a[f*FW +: FW];
                assign fb  = b[f*FW +: FW];
                assign cnt = fb[SW-1:0];
                assign sum[f*FW +: FW] = fa + fb;
                assign dif[f*FW +: FW] = fa - fb;
                assign shl[f*FW +: FW] = fa << cnt;
                assign shr[f*FW +: FW] = fa >> cnt;
            end
        end
    endgenerate

endmodule

// File: rtl/simd_lane_perm.sv
// Pack and merge for one fixed field width FW.
module simd_lane_perm #(
    parameter int N  = 64,
    parameter int FW = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] pack,
    output logic [N-1:0] mrgh,
    output logic [N-1:0] mrgl
);
    localparam int NF = N / FW;
    localparam int HF = (FW > 1) ? FW / 2 : 1;
    localparam int NH = (FW < N) ? N / (2 * FW) : 1;
    localparam int HB = N / 2;

    generate
        if (FW >= 2) begin : g_pack
            for (genvar f = 0; f < NF; f++) begin : g_fld
                assign pack[HB + f*HF +: HF] = a[f*FW +: HF];
                assign pack[f*HF +: HF]      = b[f*FW +: HF];
            end
        end else begin : g_nopack
            assign pack = '0;
        end

        if (FW < N) begin : g_merge
            for (genvar i = 0; i < NH; i++) begin : g_fld
                assign mrgh[(2*i+1)*FW +: FW] = a[HB + i*FW +: FW];
                assign mrgh[(2*i)*FW +: FW]   = b[HB + i*FW +: FW];
                assign mrgl[(2*i+1)*FW +: FW] = a[i*FW +: FW];
                assign mrgl[(2*i)*FW +: FW]   = b[i*FW +: FW];
            end
        end else begin : g_nomerge
            assign mrgh = '0;
            assign mrgl = '0;
        end
    endgenerate

endmodule

// File: rtl/simd_exec.sv
module simd_exec
    import simd_exec_pkg::*;
#(
    parameter int K  = 6,
    parameter int N  = 1 << K,
    parameter int WW = $clog2(K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [N-1:0]  op_a,
    input  logic [N-1:0]  op_b,
    input  logic [2:0]    opcode,
    input  logic [WW-1:0] fw_code,
    output logic          out_valid,
    output logic [N-1:0]  result
);
    localparam int NW = K + 1;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    logic [N-1:0] sum_w  [NW];
    logic [N-1:0] dif_w  [NW];
    logic [N-1:0] shl_w  [NW];
    logic [N-1:0] shr_w  [NW];
    logic [N-1:0] pack_w [NW];
    logic [N-1:0] mrgh_w [NW];
    logic [N-1:0] mrgl_w [NW];

    generate
        for (genvar k = 0; k < NW; k++) begin : g_width
            simd_lane_alu #(.N(N), .FW(1 << k)) u_alu (
                .a   (op_a),
                .b   (op_b),
                .sum (sum_w[k]),
                .dif (dif_w[k]),
                .shl (shl_w[k]),
                .shr (shr_w[k])
            );
            simd_lane_perm #(.N(N), .FW(1 << k)) u_perm (
                .a    (op_a),
                .b    (op_b),
                .pack (pack_w[k]),
                .mrgh (mrgh_w[k]),
                .mrgl (mrgl_w[k])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = '0;
            for (int k = 0; k < NW; k++) begin
                if (int'(fw_code) == k) begin
                    case (simd_op_e'(opcode))
                        OP_ADD:  st_d.res = sum_w[k];
                        OP_SUB:  st_d.res = dif_w[k];
                        OP_SHL:  st_d.res = shl_w[k];
                        OP_SHR:  st_d.res = shr_w[k];
                        OP_PACK: st_d.res = pack_w[k];
                        OP_MRGH: st_d.res = mrgh_w[k];
                        OP_MRGL: st_d.res = mrgl_w[k];
                        default: st_d.res = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R1: valid tracks the input one cycle later
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: unused width code gives zero
    a_r9_bad_width_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(fw_code) > K) |=> (result == '0));
    // R9: reserved opcode gives zero
    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd7) |=> (result == '0));
    // R9: pack on one-bit fields gives zero
    a_r9_pack_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd4 && fw_code == '0) |=> (result == '0));
    // R10: result holds while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R4: a zero count leaves the first operand untouched at every width
    a_r4_shl_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd2 && op_b == '0 && int'(fw_code) <= K)
        |=> (result == $past(op_a)));
    // R2: adding zero returns the first operand
    a_r2_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd0 && op_b == '0 && int'(fw_code) <= K)
        |=> (result == $past(op_a)));

endmodule

// File: tb/simd_exec_tb.sv
module simd_exec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K  = 6;
    localparam int N  = 64;
    localparam int WW = 3;

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  op;
        logic [2:0]  fw;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R2: byte fields, carries must stay inside each byte
        '{8'd2, 3'd0, 3'd3, 64'h01FF_0000_0000_80FF, 64'h0101_0000_0000_8001, 64'h0200_0000_0000_0000},
        // R2: two-bit fields 3+1 wraps to 0
        '{8'd2, 3'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h0000_0000_0000_0000},
        // R2: one-bit fields act as xor
        '{8'd2, 3'd0, 3'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0},
        // R3: 16-bit fields with borrow wrap
        '{8'd3, 3'd1, 3'd4, 64'h0000_0005_0003_0000, 64'h0001_0002_0003_0001, 64'hFFFF_0003_0000_FFFF},
        // R3: whole-register subtract
        '{8'd3, 3'd1, 3'd6, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
        // R4: nibble shifts, count upper bit ignored
        '{8'd4, 3'd2, 3'd2, 64'h1111_1111_1111_1111, 64'h4567_4567_4567_4567, 64'h1248_1248_1248_1248},
        // R4: one-bit fields never shift
        '{8'd4, 3'd2, 3'd0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0},
        // R5: byte logical right shifts, counts 0..7
        '{8'd5, 3'd3, 3'd3, 64'h8080_8080_8080_8080, 64'h0001_0203_0709_0F08, 64'h8040_2010_0140_0180},
        // R6: pack bytes to nibbles
        '{8'd6, 3'd4, 3'd3, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 64'h1234_5678_9ABC_DEF0},
        // R6: pack whole register to halves
        '{8'd6, 3'd4, 3'd6, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h3333_4444_7777_8888},
        // R7: merge-high of 16-bit fields
        '{8'd7, 3'd5, 3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'hAAAA_1111_BBBB_2222},
        // R7: merge-low of 16-bit fields
        '{8'd7, 3'd6, 3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'hCCCC_3333_DDDD_4444},
        // R7: merge-high of 32-bit fields
        '{8'd7, 3'd5, 3'd5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h1111_2222_5555_6666},
        // R8: merge-low of single bits
        '{8'd8, 3'd6, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hAAAA_AAAA_AAAA_AAAA},
        // R8: merge-high of single bits
        '{8'd8, 3'd5, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h5555_5555_5555_5555},
        // R9: pack at one-bit width is zero
        '{8'd9, 3'd4, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        // R9: merge at whole-register width is zero
        '{8'd9, 3'd5, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        // R9: width code 7 is unused
        '{8'd9, 3'd0, 3'd7, 64'h1234_1234_1234_1234, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic [2:0]    opcode = '0;
    logic [WW-1:0] fw_code = '0;
    logic          out_valid;
    logic [N-1:0]  result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_exec #(.K(K)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .opcode    (opcode),
        .fw_code   (fw_code),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the falling edge after the next rise
    task automatic issue(input logic [2:0] op, input logic [WW-1:0] fw,
                         input logic [N-1:0] a, input logic [N-1:0] b);
        opcode   = op;
        fw_code  = fw;
        op_a     = a;
        op_b     = b;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset result", result, '0);
        check("R1 reset valid", {63'd0, out_valid}, 64'd1 - 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].fw, VEC[i].a, VEC[i].b);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), result, VEC[i].exp);
        end

        // R9: reserved opcode
        issue(3'd7, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        check("R9 reserved opcode", result, '0);
        check("R1 valid after issue", {63'd0, out_valid}, 64'd1);

        // R10: idle cycles with new operands leave result unchanged
        issue(3'd0, 3'd6, 64'd40, 64'd2);
        held = result;
        check("R2 whole-register add", held, 64'd42);
        op_a    = 64'hDEAD_BEEF_DEAD_BEEF;
        op_b    = 64'h1;
        opcode  = 3'd1;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold while idle", result, held);
        check("R1 valid low while idle", {63'd0, out_valid}, 64'd0);

        // R5: whole-register right shift by low six bits of op_b (count 4)
        issue(3'd3, 3'd6, 64'hF000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFC4);
        check("R5 whole-register shr", result, 64'h0F00_0000_0000_0000);

        // R1: reset mid-run clears the output
        issue(3'd0, 3'd3, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101);
        check("R2 byte add", result, 64'h0202_0202_0202_0202);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears result", result, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule